// File: doc/BRIEF.md
# DMA Bus Handover Controller with Write Snooping

This block sits on the processor side of a shared system bus. A DMA device raises a request. The block waits until any processor bus cycle already in progress has finished, and only then grants the bus. The device answers the grant with an acknowledge. From the clock after that acknowledge, the device owns the bus, and the block watches every address and write strobe that the device drives.

The block keeps a small direct-mapped tag store that stands in for the processor's cache. It has 16 entries, each a valid bit plus a tag, for 32-bit addresses and 16-byte lines. When the device writes to a line that is present in the store, the block clears that entry. It also emits a one-clock invalidate pulse carrying the line index.

Ownership ends when the device lowers both its request and its acknowledge. The tag store is filled only through a fill port meant for testing. No data moves through this block.

Top module: `dma_handover_snoop`

## Requirements
- R1: With `cpu_busy` low, a request sampled in `IDLE` raises `grant` at the next clock edge.
- R2: A request made while `cpu_busy` is high keeps `grant` low. `grant` rises at the first clock edge that samples `cpu_busy` low.
- R3: If `dma_req` and `dma_ack` are both low while the bus is granted but not yet owned, `grant` falls at the next edge and `dma_owned` never rises.
- R4: While `grant` is high, a high `dma_ack` raises `dma_owned` at the next edge. `dma_owned` is never high without `grant`.
- R5: While the bus is owned, a write (`bus_wr`=1) whose line is present produces one clock of `inv_pulse` in the following cycle, and clears the entry. The line index is `bus_addr[7:4]` and the tag is `bus_addr[31:8]`. `inv_index` carries the index during the pulse.
- R6: An owned write to an invalid entry, or to an entry whose tag differs, produces no pulse. A repeated write to a line that was just invalidated also produces no pulse.
- R7: An owned read (`bus_wr`=0) never produces a pulse and leaves the entry valid.
- R8: Once the bus is owned, `dma_req` and `dma_ack` both low drops `grant` and `dma_owned` at the next edge.
- R9: Reset (`rst_n` low) clears `grant`, `dma_owned` and `inv_pulse`, and marks every tag entry invalid.
- R10: `fill_en` high at a clock edge makes the entry at `fill_addr[7:4]` valid with tag `fill_addr[31:8]`.
- R11: A bus write that is seen while the bus is not owned causes no pulse and leaves the tag store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_req | input | 1 | Bus request from the DMA device |
| dma_ack | input | 1 | Grant acknowledge from the DMA device |
| bus_addr | input | 32 | Address driven on the bus |
| bus_wr | input | 1 | Write strobe on the bus |
| cpu_busy | input | 1 | A processor bus cycle is in progress |
| fill_en | input | 1 | Test-only: load one tag entry |
| fill_addr | input | 32 | Test-only: address of the line to load |
| grant | output | 1 | Bus granted to the DMA device |
| inv_pulse | output | 1 | One-clock invalidate event |
| inv_index | output | 4 | Line index of the invalidated entry |
| dma_owned | output | 1 | Bus is owned by the DMA device |

## Verification
The assertions rely on a few assumptions about the inputs:
- The device raises `dma_ack` only after it has seen `grant`.
- The device holds `dma_ack` until it lowers its request.
- `fill_en` is never used in the same cycle as a snooped write to the same index.

The bench drives every input just after the falling clock edge. It raises `dma_ack` only after it has checked that `grant` is high, and it releases the request and the acknowledge together. It loads the tag store only while no write is on the bus.

// File: rtl/dmah_pkg.sv
package dmah_pkg;
  parameter int ADDR_W     = 32;
  parameter int LINE_BYTES = 16;
  parameter int ENTRIES    = 16;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_DRAIN   = 2'd1,
    HS_GRANTED = 2'd2,
    HS_OWNED   = 2'd3
  } hand_state_t;

  function automatic logic [IDX_W-1:0] line_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] line_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
endpackage

// File: rtl/dmah_arbiter.sv
module dmah_arbiter
  import dmah_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dma_req,
  input  logic dma_ack,
  input  logic cpu_busy,
  output logic grant,
  output logic owned
);
  hand_state_t state_q, state_d;
  logic        released;

  assign released = !dma_req && !dma_ack;

  always_comb begin
    state_d = state_q;
    case (state_q)
      HS_IDLE:    if (dma_req) state_d = cpu_busy ? HS_DRAIN : HS_GRANTED;
      HS_DRAIN:   if (!dma_req) state_d = HS_IDLE;
                  else if (!cpu_busy) state_d = HS_GRANTED;
      HS_GRANTED: if (dma_ack) state_d = HS_OWNED;
                  else if (!dma_req) state_d = HS_IDLE;
      HS_OWNED:   if (released) state_d = HS_IDLE;
      default:    state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  assign grant = (state_q == HS_GRANTED) || (state_q == HS_OWNED);
  assign owned = (state_q == HS_OWNED);
endmodule

// File: rtl/dmah_tagstore.sv
module dmah_tagstore
  import dmah_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              clr_en,
  output logic              probe_hit,
  output logic [IDX_W-1:0]  probe_idx
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [IDX_W-1:0]   fill_idx;

  assign fill_idx  = line_index(fill_addr);
  assign probe_idx = line_index(probe_addr);
  assign probe_hit = valid_q[probe_idx] && (tag_q[probe_idx] == line_tag(probe_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (fill_en) valid_q[fill_idx] <= 1'b1;
      if (clr_en)  valid_q[probe_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= line_tag(fill_addr);
  end
endmodule

// File: rtl/dmah_snoop.sv
module dmah_snoop
  import dmah_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             owned,
  input  logic             bus_wr,
  input  logic             hit,
  input  logic [IDX_W-1:0] hit_idx,
  output logic             clr_en,
  output logic             inv_pulse,
  output logic [IDX_W-1:0] inv_index
);
  assign clr_en = owned && bus_wr && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_pulse <= 1'b0;
      inv_index <= '0;
    end else begin
      inv_pulse <= clr_en;
      if (clr_en) inv_index <= hit_idx;
    end
  end
endmodule

// File: rtl/dma_handover_snoop.sv
module dma_handover_snoop
  import dmah_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_req,
  input  logic              dma_ack,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              cpu_busy,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              grant,
  output logic              inv_pulse,
  output logic [IDX_W-1:0]  inv_index,
  output logic              dma_owned
);
  logic             snoop_hit;
  logic             snoop_clr;
  logic [IDX_W-1:0] snoop_idx;

  dmah_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_ack(dma_ack),
    .cpu_busy(cpu_busy), .grant(grant), .owned(dma_owned)
  );

  dmah_tagstore u_tags (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_addr(fill_addr),
    .probe_addr(bus_addr), .clr_en(snoop_clr), .probe_hit(snoop_hit),
    .probe_idx(snoop_idx)
  );

  dmah_snoop u_snoop (
    .clk(clk), .rst_n(rst_n), .owned(dma_owned), .bus_wr(bus_wr),
    .hit(snoop_hit), .hit_idx(snoop_idx), .clr_en(snoop_clr),
    .inv_pulse(inv_pulse), .inv_index(inv_index)
  );
endmodule

// File: rtl/dmah_checker.sv
module dmah_checker (
  input logic clk,
  input logic rst_n,
  input logic dma_req,
  input logic dma_ack,
  input logic bus_wr,
  input logic cpu_busy,
  input logic grant,
  input logic inv_pulse,
  input logic dma_owned,
  input logic snoop_clr
);
  a_r1_grant_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(dma_req));

  a_r2_no_grant_mid_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> !$past(cpu_busy));

  a_r3_withdraw_no_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !dma_owned && !dma_req && !dma_ack) |=> (!grant && !dma_owned));

  a_r4_owned_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_owned) |-> $past(dma_ack));

  a_r4_owned_has_grant: assert property (@(posedge clk) disable iff (!rst_n)
    dma_owned |-> grant);

  a_r5_pulse_from_clear: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_clr |=> inv_pulse);

  a_r7_r11_pulse_needs_owned_write: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pulse |-> $past(dma_owned && bus_wr));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_owned && !dma_req && !dma_ack) |=> (!grant && !dma_owned));
endmodule

bind dma_handover_snoop dmah_checker u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_ack(dma_ack),
  .bus_wr(bus_wr), .cpu_busy(cpu_busy), .grant(grant),
  .inv_pulse(inv_pulse), .dma_owned(dma_owned), .snoop_clr(snoop_clr)
);

// File: tb/dma_handover_snoop_bench.sv
module dma_handover_snoop_bench;
  logic        clk = 1'b0;
  logic        rst_n, dma_req, dma_ack, bus_wr, cpu_busy, fill_en;
  logic [31:0] bus_addr, fill_addr;
  logic        grant, inv_pulse, dma_owned;
  logic [3:0]  inv_index;
  int          total = 0;
  int          bad = 0;

  always #4 clk = ~clk;

  dma_handover_snoop u_dma_handover_snoop (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_ack(dma_ack),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .cpu_busy(cpu_busy),
    .fill_en(fill_en), .fill_addr(fill_addr), .grant(grant),
    .inv_pulse(inv_pulse), .inv_index(inv_index), .dma_owned(dma_owned)
  );

  localparam logic [31:0] LINE_A = 32'h1234_5670; // index 7
  localparam logic [31:0] LINE_B = 32'hDEAD_BE20; // index 2
  localparam logic [31:0] LINE_C = 32'h0000_00F0; // index 15

  // fields: address, write strobe, expected pulse, expected index
  localparam logic [37:0] VEC [0:7] = '{
    {32'hDEAD_BE28, 1'b1, 1'b1, 4'd2},  // R5 hit, other byte of line
    {32'hDEAD_BE20, 1'b1, 1'b0, 4'd0},  // R6 already cleared
    {32'h1234_5670, 1'b0, 1'b0, 4'd0},  // R7 read
    {32'h9934_5670, 1'b1, 1'b0, 4'd0},  // R6 tag differs
    {32'h1234_567C, 1'b1, 1'b1, 4'd7},  // R5 hit; R7/R11 entry survived
    {32'h0000_00F4, 1'b1, 1'b1, 4'd15}, // R5 hit
    {32'h0000_0030, 1'b1, 1'b0, 4'd0},  // R6 never filled
    {32'h1234_5670, 1'b1, 1'b0, 4'd0}   // R6 cleared by vector 4
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] a);
    fill_en = 1'b1; fill_addr = a;
    tick();
    fill_en = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dma_req = 1'b0; dma_ack = 1'b0; bus_wr = 1'b0;
    cpu_busy = 1'b0; fill_en = 1'b0; bus_addr = '0; fill_addr = '0;
    repeat (3) tick();
    check("R9 grant", {31'd0, grant}, 32'd0);
    check("R9 owned", {31'd0, dma_owned}, 32'd0);
    check("R9 pulse", {31'd0, inv_pulse}, 32'd0);
    rst_n = 1'b1;
    tick();

    fill(LINE_A); fill(LINE_B); fill(LINE_C); // R10

    dma_req = 1'b1;
    tick();
    check("R1 grant next clock", {31'd0, grant}, 32'd1);

    bus_addr = LINE_A; bus_wr = 1'b1;
    tick();
    check("R11 write before ownership", {31'd0, inv_pulse}, 32'd0);
    check("R11 not owned", {31'd0, dma_owned}, 32'd0);
    bus_wr = 1'b0;

    dma_ack = 1'b1;
    tick();
    check("R4 owned after ack", {31'd0, dma_owned}, 32'd1);

    for (int i = 0; i < 8; i++) begin
      bus_addr = VEC[i][37:6];
      bus_wr   = VEC[i][5];
      tick();
      check("R5/R6/R7 pulse", {31'd0, inv_pulse}, {31'd0, VEC[i][4]});
      if (VEC[i][4]) check("R5 index", {28'd0, inv_index}, {28'd0, VEC[i][3:0]});
    end
    bus_wr = 1'b0;
    tick();
    check("R5 single pulse", {31'd0, inv_pulse}, 32'd0);

    dma_req = 1'b0; dma_ack = 1'b0;
    tick();
    check("R8 grant dropped", {31'd0, grant}, 32'd0);
    check("R8 owned dropped", {31'd0, dma_owned}, 32'd0);

    cpu_busy = 1'b1; dma_req = 1'b1;
    tick();
    check("R2 held while busy", {31'd0, grant}, 32'd0);
    tick();
    check("R2 still held", {31'd0, grant}, 32'd0);
    cpu_busy = 1'b0;
    tick();
    check("R2 grant after busy falls", {31'd0, grant}, 32'd1);

    dma_req = 1'b0;
    tick();
    check("R3 grant withdrawn", {31'd0, grant}, 32'd0);
    tick();
    check("R3 never owned", {31'd0, dma_owned}, 32'd0);

    fill(LINE_B);
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    dma_req = 1'b1;
    tick();
    dma_ack = 1'b1;
    tick();
    bus_addr = LINE_B; bus_wr = 1'b1;
    tick();
    check("R9 reset cleared entries", {31'd0, inv_pulse}, 32'd0);
    bus_wr = 1'b0;
    fill(LINE_B);
    bus_wr = 1'b1;
    tick();
    check("R10 fill then hit", {31'd0, inv_pulse}, 32'd1);
    check("R10 index", {28'd0, inv_index}, 32'd2);
    bus_wr = 1'b0; dma_req = 1'b0; dma_ack = 1'b0;
    tick();
    check("R8 release", {31'd0, grant}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule